// File: doc/BRIEF.md
# Not Recently Used Victim Selector

This block tracks two usage bits for each of a set of page frames. One bit records that the frame was touched recently. The other records that its contents were changed since it was filled. A memory-management controller reports every access and every refill to the block, and pulses a periodic clear that ages all frames back to "not recently touched". When the controller needs room, it raises a victim request. The block groups the frames into four priority classes by their two bits. It takes the lowest class that has any member and picks one frame of that class from a pseudo-random starting point.

The chosen frame index and its changed bit come out one cycle after the request. The controller therefore knows both which frame to evict and whether that frame must be written back first. Writing back, loading and table maintenance belong to the surrounding controller.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every frame has its touched bit and its changed bit clear, and `vict_valid`, `vict_idx` and `vict_dirty` are all 0.
- R2: An access with `acc_valid` high sets the touched bit of frame `acc_idx`. If `acc_write` is also high, it sets that frame's changed bit as well.
- R3: A cycle with `tick_clear` high clears the touched bit of every frame and leaves every changed bit as it was. An access or fill in the same cycle still leaves its own frame touched.
- R4: The class of a frame is the 2-bit value {touched, changed}: 0 is untouched and clean, 1 is untouched and changed, 2 is touched and clean, 3 is touched and changed. The victim always belongs to the lowest-numbered class that has at least one frame.
- R5: Inside the chosen class, the victim is the first member found at or after a start index taken from a free-running LFSR, wrapping past the last frame. Repeated requests against the same class contents therefore pick different members over time.
- R6: `vict_dirty` equals the changed bit that the chosen victim held at the time of the request.
- R7: `vict_valid` is high in exactly the cycle after a cycle with `vict_req` high, and `vict_idx` and `vict_dirty` are valid in that cycle. The choice uses the bits as they stood before any access, fill or clear in the request cycle.
- R8: A fill with `fill_valid` high sets the touched bit of frame `fill_idx` and replaces its changed bit with `fill_write`. A write access to the same frame in the same cycle also sets the changed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A frame is being accessed this cycle |
| acc_idx | input | IDX_W | Frame being accessed |
| acc_write | input | 1 | The access is a write |
| tick_clear | input | 1 | Periodic pulse that clears all touched bits |
| fill_valid | input | 1 | A frame has just been refilled |
| fill_idx | input | IDX_W | Frame that was refilled |
| fill_write | input | 1 | The refill was caused by a write |
| vict_req | input | 1 | Request a victim choice |
| vict_valid | output | 1 | Victim outputs are valid this cycle |
| vict_idx | output | IDX_W | Chosen victim frame |
| vict_dirty | output | 1 | Chosen victim needs a write-back |

## Verification
The frame-bit assertions take for granted that every index names an existing frame. This holds because the frame count is a power of two. The clear-cycle property also assumes nothing else touches the bits in that cycle, so it is guarded by the absence of any access or fill. The directed tests drive the clear pulse both alone and together with an access, so the guarded and the unguarded case are both exercised. The tests build class contents that leave a single candidate in the lowest class, so the exact victim can be predicted. Where a class holds several frames, the bench instead checks class membership and the spread of the choices.

// File: rtl/nru_pkg.sv
package nru_pkg;

   localparam int NUM_CLASSES = 4;

   // Eviction priority: lower value is evicted first
   typedef enum logic [1:0] {
      CLS_COLD_CLEAN = 2'd0,
      CLS_COLD_DIRTY = 2'd1,
      CLS_HOT_CLEAN  = 2'd2,
      CLS_HOT_DIRTY  = 2'd3
   } frame_class_t;

   function automatic frame_class_t frame_class(input logic touched, input logic changed);
      return frame_class_t'({touched, changed});
   endfunction

   function automatic logic class_needs_writeback(input frame_class_t c);
      return (c == CLS_COLD_DIRTY) || (c == CLS_HOT_DIRTY);
   endfunction

endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
   parameter int          LFSR_W = 8,
   parameter int          OUT_W  = 3,
   parameter logic [31:0] SEED   = 32'h0000_00A5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);

   logic [LFSR_W-1:0] state_q;
   logic              feedback;

   generate
      if (LFSR_W == 8) begin : g_w8
         assign feedback = state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3];
      end else if (LFSR_W == 16) begin : g_w16
         assign feedback = state_q[15] ^ state_q[14] ^ state_q[12] ^ state_q[3];
      end else if (LFSR_W == 32) begin : g_w32
         assign feedback = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
      end else begin : g_bad_width
         $error("nru_lfsr: LFSR_W must be 8, 16 or 32");
      end
      if (OUT_W > LFSR_W) begin : g_bad_out
         $error("nru_lfsr: OUT_W exceeds LFSR_W");
      end
      if (SEED[LFSR_W-1:0] == '0) begin : g_bad_seed
         $error("nru_lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED[LFSR_W-1:0];
      else        state_q <= {state_q[LFSR_W-2:0], feedback};
   end

   assign rnd = state_q[OUT_W-1:0];

   a_r5_lfsr_never_stuck: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

endmodule

// File: rtl/nru_frame_state.sv
module nru_frame_state #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [IDX_W-1:0]      acc_idx,
   input  logic                  acc_write,
   input  logic                  tick_clear,
   input  logic                  fill_valid,
   input  logic [IDX_W-1:0]      fill_idx,
   input  logic                  fill_write,
   output logic [NUM_FRAMES-1:0] ref_bits,
   output logic [NUM_FRAMES-1:0] mod_bits
);

   logic [NUM_FRAMES-1:0] ref_q;
   logic [NUM_FRAMES-1:0] mod_q;

   generate
      for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
         logic acc_hit;
         logic fill_hit;
         logic wr_hit;

         assign acc_hit  = acc_valid  && (acc_idx  == IDX_W'(f));
         assign fill_hit = fill_valid && (fill_idx == IDX_W'(f));
         assign wr_hit   = acc_hit && acc_write;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_q[f] <= 1'b0;
               mod_q[f] <= 1'b0;
            end else begin
               ref_q[f] <= (ref_q[f] && !tick_clear) || acc_hit || fill_hit;
               if (fill_hit) mod_q[f] <= fill_write || wr_hit;
               else if (wr_hit) mod_q[f] <= 1'b1;
            end
         end
      end
   endgenerate

   assign ref_bits = ref_q;
   assign mod_bits = mod_q;

   a_r2_access_marks_touched: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ref_q[$past(acc_idx)]);

   a_r2_write_marks_changed: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> mod_q[$past(acc_idx)]);

   a_r3_clear_ages_only_touched: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_clear && !acc_valid && !fill_valid) |=> (ref_q == '0) && (mod_q == $past(mod_q)));

   a_r8_fill_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !acc_valid) |=> ref_q[$past(fill_idx)] && (mod_q[$past(fill_idx)] == $past(fill_write)));

endmodule

// File: rtl/nru_class_pick.sv
module nru_class_pick
   import nru_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic [NUM_FRAMES-1:0] ref_bits,
   input  logic [NUM_FRAMES-1:0] mod_bits,
   input  logic [IDX_W-1:0]      start_idx,
   output logic [IDX_W-1:0]      win_idx,
   output logic                  win_dirty
);

   logic [NUM_FRAMES-1:0] cls_mask [NUM_CLASSES];
   logic [NUM_FRAMES-1:0] sel_mask;
   frame_class_t          sel_class;

   // Group frames by class
   always_comb begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
         for (int f = 0; f < NUM_FRAMES; f++) begin
            cls_mask[c][f] = (frame_class(ref_bits[f], mod_bits[f]) == frame_class_t'(c));
         end
      end
   end

   // Lowest non-empty class
   always_comb begin
      logic found;
      found     = 1'b0;
      sel_mask  = '0;
      sel_class = CLS_HOT_DIRTY;
      for (int c = 0; c < NUM_CLASSES; c++) begin
         if (!found && (|cls_mask[c])) begin
            sel_mask  = cls_mask[c];
            sel_class = frame_class_t'(c);
            found     = 1'b1;
         end
      end
   end

   // First member at or after the random start, wrapping
   always_comb begin
      logic             hit;
      logic [IDX_W-1:0] probe;
      hit     = 1'b0;
      win_idx = start_idx;
      for (int k = 0; k < NUM_FRAMES; k++) begin
         probe = start_idx + IDX_W'(k);
         if (!hit && sel_mask[probe]) begin
            win_idx = probe;
            hit     = 1'b1;
         end
      end
   end

   assign win_dirty = class_needs_writeback(sel_class);

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
   parameter int          NUM_FRAMES = 8,
   parameter int          IDX_W      = $clog2(NUM_FRAMES),
   parameter int          LFSR_W     = 8,
   parameter logic [31:0] LFSR_SEED  = 32'h0000_00A5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_write,
   input  logic             tick_clear,
   input  logic             fill_valid,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             fill_write,
   input  logic             vict_req,
   output logic             vict_valid,
   output logic [IDX_W-1:0] vict_idx,
   output logic             vict_dirty
);

   generate
      if (NUM_FRAMES < 2 || (NUM_FRAMES & (NUM_FRAMES - 1)) != 0) begin : g_bad_frames
         $error("nru_victim_sel: NUM_FRAMES must be a power of two, at least 2");
      end
      if (IDX_W != $clog2(NUM_FRAMES)) begin : g_bad_idx
         $error("nru_victim_sel: IDX_W must match NUM_FRAMES");
      end
   endgenerate

   logic [NUM_FRAMES-1:0] ref_bits;
   logic [NUM_FRAMES-1:0] mod_bits;
   logic [IDX_W-1:0]      start_idx;
   logic [IDX_W-1:0]      pick_idx;
   logic                  pick_dirty;

   nru_frame_state #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_idx    (acc_idx),
      .acc_write  (acc_write),
      .tick_clear (tick_clear),
      .fill_valid (fill_valid),
      .fill_idx   (fill_idx),
      .fill_write (fill_write),
      .ref_bits   (ref_bits),
      .mod_bits   (mod_bits)
   );

   nru_lfsr #(.LFSR_W(LFSR_W), .OUT_W(IDX_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (start_idx)
   );

   nru_class_pick #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_pick (
      .ref_bits  (ref_bits),
      .mod_bits  (mod_bits),
      .start_idx (start_idx),
      .win_idx   (pick_idx),
      .win_dirty (pick_dirty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vict_valid <= 1'b0;
         vict_idx   <= '0;
         vict_dirty <= 1'b0;
      end else begin
         vict_valid <= vict_req;
         if (vict_req) begin
            vict_idx   <= pick_idx;
            vict_dirty <= pick_dirty;
         end
      end
   end

   a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      vict_req |=> vict_valid);

   a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !vict_req |=> !vict_valid);

   a_r6_dirty_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
      vict_req |=> (vict_dirty == $past(mod_bits[pick_idx])));

   a_r4_no_cold_clean_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      (vict_req && ((~ref_bits & ~mod_bits) != '0)) |=> !vict_dirty);

endmodule

// File: tb/nru_victim_sel_bench.sv
`timescale 1ns/1ps
module nru_victim_sel_bench;

   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         acc_valid = 0, acc_write = 0, tick_clear = 0;
   logic         fill_valid = 0, fill_write = 0, vict_req = 0;
   logic [W-1:0] acc_idx = '0, fill_idx = '0;
   logic         vict_valid, vict_dirty;
   logic [W-1:0] vict_idx;

   int total = 0;
   int bad   = 0;

   bit mr [N];
   bit mm [N];
   logic [N-1:0] seen;

   always #4 clk = ~clk;

   nru_victim_sel u_nru_victim_sel (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
      .tick_clear(tick_clear),
      .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_write(fill_write),
      .vict_req(vict_req), .vict_valid(vict_valid), .vict_idx(vict_idx), .vict_dirty(vict_dirty)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: inputs set after a negedge, model updated, outputs checked at next negedge
   task automatic step(input bit av, input int ai, input bit aw, input bit tk,
                       input bit fv, input int fi, input bit fw, input bit rq, input string tag);
      bit pr [N];
      bit pm [N];
      int low;
      int cnt;
      int only;
      acc_valid = av; acc_idx = W'(ai); acc_write = aw; tick_clear = tk;
      fill_valid = fv; fill_idx = W'(fi); fill_write = fw; vict_req = rq;
      for (int f = 0; f < N; f++) begin pr[f] = mr[f]; pm[f] = mm[f]; end
      @(negedge clk);
      for (int f = 0; f < N; f++) begin
         bit ah, fh;
         ah = av && (ai == f);
         fh = fv && (fi == f);
         mr[f] = (pr[f] && !tk) || ah || fh;
         if (fh) mm[f] = fw || (ah && aw);
         else if (ah && aw) mm[f] = 1'b1;
      end
      acc_valid = 0; tick_clear = 0; fill_valid = 0; vict_req = 0;
      acc_write = 0; fill_write = 0;
      chk({tag, " R7 valid"}, int'(vict_valid), int'(rq));
      if (rq) begin
         low = 4;
         for (int f = 0; f < N; f++)
            if (int'({pr[f], pm[f]}) < low) low = int'({pr[f], pm[f]});
         cnt = 0; only = 0;
         for (int f = 0; f < N; f++)
            if (int'({pr[f], pm[f]}) == low) begin cnt++; only = f; end
         chk({tag, " R4 class"}, int'({pr[vict_idx], pm[vict_idx]}), low);
         chk({tag, " R6 dirty"}, int'(vict_dirty), int'(pm[vict_idx]));
         if (cnt == 1) chk({tag, " R4 unique"}, int'(vict_idx), only);
         seen[vict_idx] = 1'b1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
   endtask

   task automatic t_reset;
      chk("R1 valid", int'(vict_valid), 0);
      chk("R1 idx", int'(vict_idx), 0);
      chk("R1 dirty", int'(vict_dirty), 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, "R1 req");
      chk("R1 clean victim", int'(vict_dirty), 0);
   endtask

   task automatic t_access;
      for (int f = 0; f < N; f++) if (f != 5) step(1, f, 0, 0, 0, 0, 0, 0, "R2 rd");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R2 lone");
      chk("R2 lone idx", int'(vict_idx), 5);
      step(1, 5, 1, 0, 0, 0, 0, 0, "R2 wr");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R2 after wr");
      chk("R2 hot clean", int'(vict_dirty), 0);
   endtask

   task automatic t_clear;
      for (int f = 0; f < N; f++) step(1, f, 1, 0, 0, 0, 0, 0, "R3 wr");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R3 tick");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R3 aged");
      chk("R3 changed kept", int'(vict_dirty), 1);
      for (int f = 0; f < N; f++) if (f != 2) step(1, f, 0, 0, 0, 0, 0, 0, "R3 rd");
      step(1, 6, 0, 1, 0, 0, 0, 0, "R3 tick+acc");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R3 probe");
   endtask

   task automatic t_fill;
      step(0, 0, 0, 1, 0, 0, 0, 0, "R8 tick");
      step(0, 0, 0, 0, 1, 4, 0, 0, "R8 fill clean");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R8 not picked");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R8 tick2");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R8 lone");
      chk("R8 idx", int'(vict_idx), 4);
      chk("R8 dirty cleared", int'(vict_dirty), 0);
      step(1, 1, 0, 0, 1, 1, 1, 0, "R8 fill wr");
   endtask

   task automatic t_order;
      // Frame 3 alone in class 2, all others class 3
      for (int f = 0; f < N; f++) step(0, 0, 0, 0, 1, f, (f != 3), 0, "R4 setup");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R4 class2");
      chk("R4 idx3", int'(vict_idx), 3);
      step(0, 0, 0, 1, 0, 0, 0, 0, "R4 tick");
      for (int f = 0; f < N; f++) if (f != 7) step(1, f, 0, 0, 0, 0, 0, 0, "R4 rd");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R4 class1");
      chk("R4 idx7", int'(vict_idx), 7);
      chk("R4 idx7 dirty", int'(vict_dirty), 1);
      // Same-cycle access to the lone candidate does not alter the choice (R7)
      step(1, 7, 0, 0, 0, 0, 0, 1, "R7 same cycle");
      chk("R7 pre-update idx", int'(vict_idx), 7);
   endtask

   task automatic t_spread;
      for (int f = 0; f < N; f++) step(0, 0, 0, 0, 1, f, 0, 0, "R5 fill");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R5 tick");
      seen = '0;
      for (int i = 0; i < 24; i++) begin
         step(0, 0, 0, 0, 0, 0, 0, 1, "R5 req");
         idle(i % 3);
      end
      total++;
      if ($countones(seen) < 3) begin
         bad++;
         $display("FAIL R5 distinct victims actual=%0d expected>=3", $countones(seen));
      end
   endtask

   initial begin
      for (int f = 0; f < N; f++) begin mr[f] = 0; mm[f] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_access;
      t_clear;
      t_fill;
      t_order;
      t_spread;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule